// File: doc/BRIEF.md
# Gated Edge-Counting Frequency Meter

This block measures the frequency of a dedicated digital input by counting its rising edges over a fixed gate window. Software first writes a 4-bit setup word holding a measurement mode and a gate-time code. A separate one-cycle start command then opens the gate. While the gate is open, rising edges of the input are counted after a two-flop synchronizer. When the window ends, the count is copied into a result register and a sticky completion flag is raised.

The gate window is built from a slow timing tick that is derived from the system clock. The tick divider is a parameter, and 1 kHz is the intended rate. The divider restarts at every start command, so a window lasts exactly 1, 4, 8 or 32 tick periods. A block-level inhibit input stands for the low-power, halt and oscillator-stop states. While it is high, no edge is counted. The edge counter saturates at its maximum value and does not wrap.

Top module: `freq_gate_counter`

## Requirements
- R1: After reset, `busy`, `done` and `result` are all zero.
- R2: A `cfg_wr` pulse stores `cfg_data`. Bits 3:2 hold the mode and bits 1:0 hold the gate code. The stored word is used only when the next `start` is sampled, so a write during a measurement does not change that measurement.
- R3: After a `start`, `busy` is high for exactly N × TICK_DIV clock cycles. N is 1 for gate code 00, 4 for code 01, 8 for code 10 and 32 for code 11.
- R4: With mode code 00, each rising edge of `sig_in` is counted if it is seen after the synchronizer in a cycle where `busy` is high. The total is copied to `result` in the cycle the gate closes.
- R5: `done` is set in the cycle the gate closes. It stays set, with `result` held, until the next `start` or reset. `done` is cleared in the cycle `start` is sampled.
- R6: A `start` during a measurement restarts the full gate window and clears the running count.
- R7: An edge seen while `inhibit` is high is not counted.
- R8: Mode codes 01, 10 and 11 are reserved. The gate still runs and `done` is still set, but the result is 0.
- R9: The count saturates at 2^CNT_W − 1 and does not wrap.
- R10: Edges on `sig_in` while no measurement is running leave `result` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Setup-word write strobe |
| cfg_data | input | 4 | Setup word: [3:2] mode, [1:0] gate code |
| start | input | 1 | Start (or restart) a measurement |
| inhibit | input | 1 | Blocks counting (low-power, halt or oscillator-stop state) |
| sig_in | input | 1 | Asynchronous signal whose frequency is measured |
| busy | output | 1 | Gate window is open |
| done | output | 1 | Sticky end-of-count flag |
| result | output | CNT_W | Edge count latched at gate close |

## Verification
The hardest cases to reach from the ports involve timing inside a running gate: a restart or a setup write partway through a window, and inhibit toggling mid-window. The stimulus lines these up by waiting a chosen number of cycles after `start`, while a free-running input toggler keeps edges arriving. Saturation needs many more edges than the counter can hold. The bench reaches it by shrinking the tick divider and the counter width through parameters and running the longest gate with the fastest input.

// File: rtl/ufc_pkg.sv
package ufc_pkg;

    typedef enum logic [1:0] {
        MODE_FREQ  = 2'b00,
        MODE_RSV1  = 2'b01,
        MODE_RSV2  = 2'b10,
        MODE_RSV3  = 2'b11
    } ufc_mode_e;

    typedef struct packed {
        ufc_mode_e  mode;
        logic [1:0] gate;
    } ufc_cfg_t;

    localparam int TICKS_W = 6;

    function automatic logic [TICKS_W-1:0] gate_ticks(input logic [1:0] code);
        case (code)
            2'b00:   gate_ticks = 6'd1;
            2'b01:   gate_ticks = 6'd4;
            2'b10:   gate_ticks = 6'd8;
            default: gate_ticks = 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/ufc_tick_gen.sv
module ufc_tick_gen #(
    parameter int TICK_DIV = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } tick_st_t;

    tick_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.div == DIV_LAST);
        if (restart || !run) begin
            st_d.div = '0;
        end else if (tick) begin
            st_d.div = '0;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r3_div_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.div <= DIV_LAST);

endmodule

// File: rtl/ufc_edge_sync.sv
module ufc_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_st_t;

    sync_st_t st_q, st_d;

    always_comb begin
        st_d.meta = sig_in;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
        rise      = st_q.sync && !st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r4_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/ufc_gate_ctrl.sv
module ufc_gate_ctrl
    import ufc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] gate_code,
    input  logic       tick,
    output logic       busy,
    output logic       close
);
    typedef struct packed {
        logic               busy;
        logic [TICKS_W-1:0] ticks;
        logic [TICKS_W-1:0] limit;
    } gate_st_t;

    gate_st_t st_q, st_d;

    always_comb begin
        st_d  = st_q;
        close = st_q.busy && tick && !start && (st_q.ticks == st_q.limit - 1'b1);
        if (start) begin
            st_d.busy  = 1'b1;
            st_d.ticks = '0;
            st_d.limit = gate_ticks(gate_code);
        end else if (close) begin
            st_d.busy  = 1'b0;
            st_d.ticks = '0;
        end else if (st_q.busy && tick) begin
            st_d.ticks = st_q.ticks + 1'b1;
        end
        busy = st_q.busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r3_ticks_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.ticks < st_q.limit));

    a_r6_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.busy && st_q.ticks == '0));

endmodule

// File: rtl/freq_gate_counter.sv
module freq_gate_counter
    import ufc_pkg::*;
#(
    parameter int TICK_DIV = 200000,
    parameter int CNT_W    = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [3:0]       cfg_data,
    input  logic             start,
    input  logic             inhibit,
    input  logic             sig_in,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] result
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        ufc_cfg_t         cfg;
        ufc_mode_e        run_mode;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] res;
        logic             done;
    } top_st_t;

    top_st_t st_q, st_d;

    logic tick, rise, gate_busy, gate_close, count_en;

    ufc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .run     (gate_busy),
        .tick    (tick)
    );

    ufc_edge_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (sig_in),
        .rise   (rise)
    );

    ufc_gate_ctrl u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .gate_code (st_q.cfg.gate),
        .tick      (tick),
        .busy      (gate_busy),
        .close     (gate_close)
    );

    always_comb begin
        st_d     = st_q;
        count_en = gate_busy && rise && !inhibit
                   && (st_q.run_mode == MODE_FREQ) && (st_q.cnt != CNT_MAX);
        if (start) begin
            st_d.run_mode = st_q.cfg.mode;
            st_d.cnt      = '0;
            st_d.done     = 1'b0;
        end else begin
            if (count_en) st_d.cnt = st_q.cnt + 1'b1;
            if (gate_close) begin
                st_d.res  = st_d.cnt;
                st_d.done = 1'b1;
            end
        end
        if (cfg_wr) begin
            st_d.cfg = ufc_cfg_t'(cfg_data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = gate_busy;
    assign done   = st_q.done;
    assign result = st_q.res;

    a_r5_done_excludes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.done && gate_busy));

    a_r5_close_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_busy) |-> st_q.done);

    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX && !start) |=> (st_q.cnt == CNT_MAX));

    a_r7_inhibit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !start) |=> $stable(st_q.cnt));

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_busy && st_q.run_mode != MODE_FREQ) |-> (st_q.cnt == '0));

    a_r10_idle_result: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_busy && !start) |=> $stable(st_q.res));

endmodule

// File: tb/freq_gate_counter_tb.sv
module freq_gate_counter_tb;
    localparam int TICK_DIV = 10;
    localparam int CNT_W    = 6;
    localparam int MAXV     = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [3:0] cfg_data = 4'd0;
    logic start = 1'b0;
    logic inhibit = 1'b0;
    logic sig_in = 1'b0;
    logic busy, done;
    logic [CNT_W-1:0] result;

    int errors = 0;
    int checks = 0;
    int sig_half = 0;

    always #2.5 clk = ~clk;

    freq_gate_counter #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .start(start), .inhibit(inhibit), .sig_in(sig_in),
        .busy(busy), .done(done), .result(result)
    );

    // behavioural reference
    int  m_cfg, m_mode_run, m_left, m_cnt, m_res;
    bit  m_busy, m_done, m_s1, m_s2, m_s3;

    function automatic int ticks_of(input int code);
        case (code & 3)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 32;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cfg = 0; m_mode_run = 0; m_left = 0; m_cnt = 0; m_res = 0;
            m_busy = 0; m_done = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            bit pulse;
            pulse = m_s2 && !m_s3;
            if (start) begin
                m_busy = 1; m_left = ticks_of(m_cfg) * TICK_DIV;
                m_mode_run = (m_cfg >> 2) & 3; m_cnt = 0; m_done = 0;
            end else if (m_busy) begin
                if (pulse && !inhibit && m_mode_run == 0 && m_cnt < MAXV) m_cnt++;
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0; m_res = m_cnt; m_done = 1;
                end
            end
            if (cfg_wr) m_cfg = int'(cfg_data);
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = sig_in;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R3 busy", int'(busy), int'(m_busy));
            check("R5 done", int'(done), int'(m_done));
            check("R4 result", int'(result), m_res);
        end
    end

    // free-running input toggler
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (sig_half > 0) begin
                ph++;
                if (ph >= sig_half) begin sig_in = ~sig_in; ph = 0; end
            end
        end
    end

    task automatic write_cfg(input int mode, input int gate);
        @(negedge clk);
        cfg_data = 4'((mode << 2) | gate); cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_meas(input string req, input int gate, output int len);
        len = 0;
        pulse_start();
        while (busy) begin
            len++;
            @(negedge clk);
        end
        check({req, " gate length"}, len, ticks_of(gate) * TICK_DIV);
        check({req, " done set"}, int'(done), 1);
    endtask

    initial begin
        int len, hold;
        repeat (3) @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 result", int'(result), 0);
        rst_n = 1'b1;

        // R3/R4: each gate code with different input rates
        sig_half = 3;
        for (int g = 0; g < 4; g++) begin
            write_cfg(0, g);
            run_meas("R3", g, len);
            check("R4 result matches model", int'(result), m_res);
        end
        sig_half = 2;
        write_cfg(0, 1);
        run_meas("R4", 1, len);
        check("R4 edge count", int'(result), (4 * TICK_DIV) / 4);

        // R9 saturation: longest gate, fastest input
        sig_half = 2;
        write_cfg(0, 3);
        run_meas("R9", 3, len);
        check("R9 saturated", int'(result), MAXV);

        // R5 done and result held while idle; R10 idle edges ignored
        hold = int'(result);
        repeat (40) @(negedge clk);
        check("R5 done sticky", int'(done), 1);
        check("R10 result unchanged", int'(result), hold);

        // R2 setup write during a run does not change the running gate
        write_cfg(0, 0);
        pulse_start();
        @(negedge clk);
        cfg_data = 4'b0011; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        check("R5 done cleared by start", int'(done), 0);
        while (busy) @(negedge clk);
        check("R2 result", int'(result), m_res);
        run_meas("R2 new gate", 3, len);

        // R6 restart mid-window
        sig_half = 3;
        write_cfg(0, 1);
        pulse_start();
        repeat (17) @(negedge clk);
        len = 0;
        pulse_start();
        while (busy) begin len++; @(negedge clk); end
        check("R6 restarted length", len, 4 * TICK_DIV);
        check("R6 result", int'(result), m_res);

        // R7 inhibit for whole gate, then for half
        inhibit = 1'b1;
        run_meas("R7", 1, len);
        check("R7 inhibited count", int'(result), 0);
        pulse_start();
        repeat (20) @(negedge clk);
        inhibit = 1'b0;
        while (busy) @(negedge clk);
        check("R7 partial inhibit", int'(result), m_res);
        check("R7 fewer than full", int'(result < 10), 1);

        // R8 reserved modes
        for (int md = 1; md < 4; md++) begin
            write_cfg(md, 0);
            run_meas("R8", 0, len);
            check("R8 reserved result", int'(result), 0);
        end

        // R1 reset mid-run
        write_cfg(0, 2);
        pulse_start();
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset result", int'(result), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule